// File: doc/BRIEF.md
# ATA Channel Task-File Register Bank

This block is the device-side register bank for a single ATA channel. A host reaches it through a 3-bit offset into the command block, plus one shared port in the control block. That port is the device control register when written and the alternate status when read. The bank holds the features, device/head, command and control bytes. It also holds four two-byte slots behind offsets 2 to 5, which carry the sector count and the six LBA address bytes used for 48-bit addressing.

Each of the four slots is a two-deep byte stack. Every host write to a slot moves the current low byte into the high-order position and stores the new byte as the low byte. A host therefore loads a 16-bit value by writing the high-order byte first. Reads of a slot return the low byte, or the high-order byte when the host has set the high-order-byte select bit (bit 7) of the control register. Command execution and data transfers live elsewhere. The bank passes them a one-cycle command strobe with the command byte, and it takes a status byte, an error byte and an interrupt request pulse from them.

Top module: `ata_taskfile_bank`

## Requirements
- R1: After reset every stored byte (slots, features, device/head, control, command byte) is 0, no interrupt is pending, `intrq` and `cmdStrobe` are low, and `hostRdata` is 0.
- R2: A write to command offset 2, 3, 4 or 5 copies that slot's low byte into its high byte and stores the written byte as the new low byte. No other slot changes.
- R3: A read of offsets 2 to 5 returns the slot's low byte when control bit 7 is 0, and the high byte when it is 1.
- R4: A write to control-block offset 2 stores the whole byte in the control register (`ctlOut`). Any write to command offsets 1 to 7 clears control bit 7 and leaves the other control bits unchanged.
- R5: A write to command offset 7 raises `cmdStrobe` for exactly the next cycle, with `cmdByte` holding the written byte. It also clears any pending interrupt.
- R6: A high `intReq` sets the pending interrupt. `intrq` is high when an interrupt is pending and control bit 1 (interrupt disable) is 0. Setting bit 1 masks the output without losing the pending state.
- R7: A read of command offset 7 returns `devStatus` and clears the pending interrupt. A read of control offset 2 returns `devStatus` and leaves the pending interrupt unchanged. If `intReq` is high in the same cycle, the set wins.
- R8: A read of offset 1 returns `errIn`, and a write to offset 1 sets `featOut`. Offset 6 reads back the byte last written to it (`devHead`). In that byte, bit 4 is the slave select and bit 6 the LBA select.
- R9: Writes to command offset 0, or to any control-block offset other than 2, change no output. Reads of those offsets return 0.
- R10: `secCount` is {high, low} of slot 2. `lbaOut` is {slot5 high, slot4 high, slot3 high, slot5 low, slot4 low, slot3 low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write request this cycle |
| hostRd | input | 1 | Host read request this cycle |
| blkCtl | input | 1 | 1 selects the control block, 0 the command block |
| regAddr | input | 3 | Register offset within the block |
| hostWdata | input | 8 | Write byte |
| hostRdata | output | 8 | Read byte, valid in the cycle `hostRd` is high |
| devStatus | input | 8 | Status byte from the execution logic |
| errIn | input | 8 | Error byte from the execution logic |
| intReq | input | 1 | Interrupt request pulse from the execution logic |
| featOut | output | 8 | Features byte |
| secCount | output | 16 | Sector count, both bytes |
| lbaOut | output | 48 | 48-bit address assembled from the slots |
| devHead | output | 8 | Device/head byte |
| ctlOut | output | 8 | Device control register |
| cmdStrobe | output | 1 | One-cycle pulse after a command write |
| cmdByte | output | 8 | Last command byte written |
| intrq | output | 1 | Channel interrupt output |

## Verification
The assertions check several things on every cycle: the shift of a slot after a write to it, the clearing of the high-byte select after command-block writes, the origin of each command strobe, and the behaviour of the interrupt after a status read or a mask write. Only the bench's scenarios show three further things. The first is the read view seen through both settings of the select bit, over random mixes of writes. The second is that an alternate status read leaves the interrupt pending. The third is that unused offsets change nothing, and the assembled address and count ordering.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int BYTE_W  = 8;
  localparam int SLOT_N  = 4;
  localparam int SLOT_IW = $clog2(SLOT_N);

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ERR,
    RD_SLOT,
    RD_DEV,
    RD_STAT
  } rdSel_t;

  typedef struct packed {
    logic              wrFeat;
    logic [SLOT_N-1:0] wrSlot;
    logic              wrDev;
    logic              wrCmd;
    logic              wrCtl;
    logic              clrHob;
    logic              rdStatus;
    rdSel_t            rdSel;
    logic [SLOT_IW-1:0] slotIdx;
  } tfStrobe_t;
endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import tf_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int OFF_ERR  = 1,
  parameter int OFF_SLOT = 2,
  parameter int OFF_DEV  = 6,
  parameter int OFF_CMD  = 7,
  parameter int OFF_ALT  = 2
) (
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              blkCtl,
  input  logic [ADDR_W-1:0] regAddr,
  output tfStrobe_t         strobe
);
  localparam int SLOT_LAST = OFF_SLOT + SLOT_N - 1;

  logic cmdBlk, isErr, isDev, isCmd, isAlt, isSlot;
  logic [SLOT_IW-1:0] idx;

  always_comb begin
    cmdBlk = !blkCtl;
    isErr  = cmdBlk && (int'(regAddr) == OFF_ERR);
    isDev  = cmdBlk && (int'(regAddr) == OFF_DEV);
    isCmd  = cmdBlk && (int'(regAddr) == OFF_CMD);
    isAlt  = blkCtl && (int'(regAddr) == OFF_ALT);
    isSlot = cmdBlk && (int'(regAddr) >= OFF_SLOT) && (int'(regAddr) <= SLOT_LAST);
    idx    = SLOT_IW'(int'(regAddr) - OFF_SLOT);
  end

  for (genvar i = 0; i < SLOT_N; i++) begin : g_slotDec
    assign strobe.wrSlot[i] = hostWr && isSlot && (idx == SLOT_IW'(i));
  end

  always_comb begin
    strobe.wrFeat   = hostWr && isErr;
    strobe.wrDev    = hostWr && isDev;
    strobe.wrCmd    = hostWr && isCmd;
    strobe.wrCtl    = hostWr && isAlt;
    strobe.clrHob   = hostWr && cmdBlk && (regAddr != '0);
    strobe.rdStatus = hostRd && isCmd;
    strobe.slotIdx  = idx;
    strobe.rdSel    = RD_NONE;
    if (hostRd) begin
      if (isErr)              strobe.rdSel = RD_ERR;
      else if (isSlot)        strobe.rdSel = RD_SLOT;
      else if (isDev)         strobe.rdSel = RD_DEV;
      else if (isCmd || isAlt) strobe.rdSel = RD_STAT;
    end
  end
endmodule

// File: rtl/tf_datapath.sv
module tf_datapath
  import tf_pkg::*;
#(
  parameter int HOB_BIT  = 7,
  parameter int NIEN_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tfStrobe_t         strobe,
  input  logic [BYTE_W-1:0] hostWdata,
  input  logic [BYTE_W-1:0] devStatus,
  input  logic [BYTE_W-1:0] errIn,
  input  logic              intReq,
  output logic [BYTE_W-1:0] hostRdata,
  output logic [BYTE_W-1:0] featOut,
  output logic [2*BYTE_W-1:0] secCount,
  output logic [6*BYTE_W-1:0] lbaOut,
  output logic [BYTE_W-1:0] devHead,
  output logic [BYTE_W-1:0] ctlOut,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              intrq
);
  logic [BYTE_W-1:0] slotLo [SLOT_N];
  logic [BYTE_W-1:0] slotHi [SLOT_N];
  logic [BYTE_W-1:0] ctlReg;
  logic              pending;

  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotLo[i] <= '0;
        slotHi[i] <= '0;
      end else if (strobe.wrSlot[i]) begin
        slotHi[i] <= slotLo[i];
        slotLo[i] <= hostWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featOut   <= '0;
      devHead   <= '0;
      ctlReg    <= '0;
      cmdByte   <= '0;
      cmdStrobe <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (strobe.wrFeat) featOut <= hostWdata;
      if (strobe.wrDev)  devHead <= hostWdata;
      if (strobe.wrCmd)  cmdByte <= hostWdata;
      cmdStrobe <= strobe.wrCmd;
      if (strobe.wrCtl)       ctlReg <= hostWdata;
      else if (strobe.clrHob) ctlReg[HOB_BIT] <= 1'b0;
      if (intReq)                               pending <= 1'b1;
      else if (strobe.rdStatus || strobe.wrCmd) pending <= 1'b0;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_ERR:  hostRdata = errIn;
      RD_SLOT: hostRdata = ctlReg[HOB_BIT] ? slotHi[strobe.slotIdx] : slotLo[strobe.slotIdx];
      RD_DEV:  hostRdata = devHead;
      RD_STAT: hostRdata = devStatus;
      default: hostRdata = '0;
    endcase
  end

  assign ctlOut   = ctlReg;
  assign intrq    = pending && !ctlReg[NIEN_BIT];
  assign secCount = {slotHi[0], slotLo[0]};
  assign lbaOut   = {slotHi[3], slotHi[2], slotHi[1], slotLo[3], slotLo[2], slotLo[1]};
endmodule

// File: rtl/ata_taskfile_bank.sv
module ata_taskfile_bank
  import tf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic        blkCtl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  input  logic [7:0]  devStatus,
  input  logic [7:0]  errIn,
  input  logic        intReq,
  output logic [7:0]  featOut,
  output logic [15:0] secCount,
  output logic [47:0] lbaOut,
  output logic [7:0]  devHead,
  output logic [7:0]  ctlOut,
  output logic        cmdStrobe,
  output logic [7:0]  cmdByte,
  output logic        intrq
);
  tfStrobe_t strobe;

  tf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .hostWr (hostWr),
    .hostRd (hostRd),
    .blkCtl (blkCtl),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  tf_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostWdata(hostWdata),
    .devStatus(devStatus),
    .errIn    (errIn),
    .intReq   (intReq),
    .hostRdata(hostRdata),
    .featOut  (featOut),
    .secCount (secCount),
    .lbaOut   (lbaOut),
    .devHead  (devHead),
    .ctlOut   (ctlOut),
    .cmdStrobe(cmdStrobe),
    .cmdByte  (cmdByte),
    .intrq    (intrq)
  );
endmodule

// File: rtl/ata_taskfile_bank_chk.sv
module ata_taskfile_bank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostWr,
  input logic        hostRd,
  input logic        blkCtl,
  input logic [2:0]  regAddr,
  input logic [7:0]  hostWdata,
  input logic        intReq,
  input logic [15:0] secCount,
  input logic [7:0]  ctlOut,
  input logic        cmdStrobe,
  input logic [7:0]  cmdByte,
  input logic        intrq
);
  logic wrSec, wrCmdBlk, wrCmdReg, rdStat, maskWr;
  assign wrSec    = hostWr && !blkCtl && (regAddr == 3'd2);
  assign wrCmdBlk = hostWr && !blkCtl && (regAddr != 3'd0);
  assign wrCmdReg = hostWr && !blkCtl && (regAddr == 3'd7);
  assign rdStat   = hostRd && !blkCtl && (regAddr == 3'd7) && !hostWr && !intReq;
  assign maskWr   = hostWr && blkCtl && (regAddr == 3'd2) && hostWdata[1] && !wrCmdBlk;

  // R2: the sector count slot shifts on each write
  a_r2_slot_shift: assert property (@(posedge clk) disable iff (!rstN)
    wrSec |=> (secCount[15:8] == $past(secCount[7:0])) && (secCount[7:0] == $past(hostWdata)));

  // R4: command-block writes clear the high-byte select
  a_r4_hob_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmdBlk && !(hostWr && blkCtl)) |=> !ctlOut[7]);

  // R5: each strobe follows a command write and carries its byte
  a_r5_strobe_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdStrobe) |-> $past(wrCmdReg) && (cmdByte == $past(hostWdata)));

  // R6: a mask write silences the interrupt output
  a_r6_mask: assert property (@(posedge clk) disable iff (!rstN)
    maskWr |=> !intrq);

  // R7: a status read with no new request clears the interrupt
  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdStat |=> !intrq);
endmodule

bind ata_taskfile_bank ata_taskfile_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .blkCtl(blkCtl),
  .regAddr(regAddr), .hostWdata(hostWdata), .intReq(intReq), .secCount(secCount),
  .ctlOut(ctlOut), .cmdStrobe(cmdStrobe), .cmdByte(cmdByte), .intrq(intrq)
);

// File: tb/tb_ata_taskfile_bank.sv
module tb_ata_taskfile_bank;
  logic clk = 0, rstN = 0;
  logic hostWr = 0, hostRd = 0, blkCtl = 0, intReq = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] hostWdata = 0, devStatus = 8'h50, errIn = 8'h04;
  logic [7:0] hostRdata, featOut, devHead, ctlOut, cmdByte;
  logic [15:0] secCount;
  logic [47:0] lbaOut;
  logic cmdStrobe, intrq;
  int errors = 0, checks = 0;
  logic [7:0] mLo [4];
  logic [7:0] mHi [4];
  logic mHob;

  always #4 clk = ~clk;

  ata_taskfile_bank dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic blk, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1; blkCtl = blk; regAddr = a; hostWdata = d;
    @(posedge clk);
    @(negedge clk);
    hostWr = 0;
    if (!blk && a >= 2 && a <= 5) begin
      mHi[a-2] = mLo[a-2]; mLo[a-2] = d;
    end
    if (blk && a == 2) mHob = d[7];
    else if (!blk && a != 0) mHob = 0;
  endtask

  task automatic rd(input logic blk, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostRd = 1; blkCtl = blk; regAddr = a;
    #1 d = hostRdata;
    @(posedge clk);
    @(negedge clk);
    hostRd = 0;
  endtask

  function automatic logic [7:0] expSlot(input int i);
    return mHob ? mHi[i] : mLo[i];
  endfunction

  task automatic pulseInt();
    @(negedge clk); intReq = 1;
    @(negedge clk); intReq = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin mLo[i] = 0; mHi[i] = 0; end
    mHob = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 ctl", ctlOut, 0); chk("R1 intrq", intrq, 0);
    chk("R1 strobe", cmdStrobe, 0); chk("R1 sec", secCount, 0);
    rd(0, 3'd4, d); chk("R1 slot read", d, 0);
    // R2/R3 directed
    wr(0, 3'd2, 8'h12); wr(0, 3'd2, 8'h34);
    rd(0, 3'd2, d); chk("R3 low view", d, 8'h34);
    wr(1, 3'd2, 8'h80);
    rd(0, 3'd2, d); chk("R3 high view", d, 8'h12);
    chk("R2 secCount", secCount, 16'h1234);
    // R4 clear of HOB by device/head write
    wr(0, 3'd6, 8'hE5);
    chk("R4 hob cleared", ctlOut, 8'h00);
    rd(0, 3'd6, d); chk("R8 devhead read", d, 8'hE5);
    chk("R8 slave bit", devHead[4], 1'b0); chk("R8 lba bit", devHead[6], 1'b1);
    // R8 features / error
    wr(0, 3'd1, 8'h5A); chk("R8 features", featOut, 8'h5A);
    rd(0, 3'd1, d); chk("R8 error read", d, 8'h04);
    // R10 address ordering
    wr(0, 3'd3, 8'hA3); wr(0, 3'd3, 8'hA0);
    wr(0, 3'd4, 8'hA4); wr(0, 3'd4, 8'hA1);
    wr(0, 3'd5, 8'hA5); wr(0, 3'd5, 8'hA2);
    chk("R10 lba", lbaOut, 48'hA5A4A3A2A1A0);
    // R5 command strobe
    pulseInt();
    chk("R6 intrq set", intrq, 1);
    @(negedge clk); hostWr = 1; blkCtl = 0; regAddr = 7; hostWdata = 8'hEC;
    @(negedge clk); hostWr = 0;
    chk("R5 strobe high", cmdStrobe, 1); chk("R5 cmd byte", cmdByte, 8'hEC);
    chk("R5 int cleared", intrq, 0);
    @(negedge clk); chk("R5 strobe one cycle", cmdStrobe, 0);
    mHob = 0;
    // R7 alt status vs status
    pulseInt();
    rd(1, 3'd2, d); chk("R7 alt value", d, 8'h50); chk("R7 alt keeps int", intrq, 1);
    rd(0, 3'd7, d); chk("R7 status value", d, 8'h50); chk("R7 status clears", intrq, 0);
    // R6 mask
    wr(1, 3'd2, 8'h02); pulseInt(); chk("R6 masked", intrq, 0);
    wr(1, 3'd2, 8'h00); chk("R6 unmasked pending", intrq, 1);
    rd(0, 3'd7, d);
    // R9 unused offsets
    wr(1, 3'd0, 8'hFF); chk("R9 ctl offset0 write", ctlOut, 8'h00);
    wr(0, 3'd0, 8'h77); chk("R9 data write", secCount, 16'h1234);
    rd(0, 3'd0, d); chk("R9 data read", d, 0);
    rd(1, 3'd3, d); chk("R9 ctl offset3 read", d, 0);
    // R2/R3/R4 random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 3);
      logic [2:0] a = 3'($urandom_range(2, 5));
      if (op == 0) wr(0, a, 8'($urandom));
      else if (op == 1) wr(1, 3'd2, {1'($urandom), 7'b0});
      else begin
        rd(0, a, d);
        chk("R3 random read", d, expSlot(int'(a) - 2));
      end
    end
    chk("R4 random hob", ctlOut[7], mHob);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule